// File: doc/BRIEF.md
# Histogram Memory Host Command Port

This block sits between a host bus and the host side of a dual-port histogram memory, plus the few control registers of a spectrum accumulator. The host presents a function code, a subaddress, a one-cycle strobe and write data. The block turns each recognised code pair into one action: reset the address pointer, clear one memory word, read one memory word, load the run-length counter, load the mode, arm accumulation, or sense the run-complete flag.

The memory has no random access from the host. A pointer inside the block supplies the address, and every memory access advances it by one. The pointer wraps modulo the depth. Clearing the spectrum is therefore one pointer reset followed by a run of clear commands. Reading it out is one pointer reset followed by a run of read commands.

While the acquisition side owns the memory (`acq_active` high), the host is refused with a not-ready response. Only the flag sense is still served. An unknown code pair does nothing and gets no response.

Top module: `hist_host_port`

## Requirements
- R1: After reset, no response, load strobe or memory access is active, and the first memory command uses address 0.
- R2: Function 16, subaddress 0 (clear word) writes zero to the pointer address for one cycle (`mem_en` and `mem_we` high) and advances the pointer by one.
- R3: Function 0, subaddress 0 (read word) reads the pointer address and advances the pointer by one. Two cycles after the strobe cycle, `rsp_rdata` carries the stored word in bits 15:0 with bits 23:16 zero, and `rsp_valid` is high.
- R4: Function 9, subaddress 0 sets the pointer to zero, including in the middle of a block, and is answered with `rsp_valid`.
- R5: The pointer wraps from the last address (255 by default) to 0, so a block of 256 accesses leaves it at 0.
- R6: Function 16, subaddress 2 pulses `ld_count` for one cycle, with `reg_value` equal to write data bits 15:0.
- R7: Function 16, subaddress 3 pulses `ld_mode` for one cycle, with the mode in `reg_value` bit 0.
- R8: Function 9, subaddress 1 pulses `arm_pulse` for one cycle.
- R9: Function 0, subaddress 1 returns the run-complete flag in `rsp_rdata` bit 0, with all other bits zero. It is served even while acquisition is active.
- R10: While `acq_active` is high, every other recognised command gets `rsp_busy` and not `rsp_valid`. It causes no memory access and no load strobe, and it leaves the pointer unchanged.
- R11: An unrecognised function/subaddress pair gives neither `rsp_valid` nor `rsp_busy`, no strobe and no memory access, and leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_stb | input | 1 | One-cycle command strobe |
| cmd_fn | input | 5 | Function code |
| cmd_sub | input | 4 | Subaddress code |
| cmd_wdata | input | 24 | Host write data |
| rsp_valid | output | 1 | Command accepted and answered |
| rsp_busy | output | 1 | Command refused, acquisition owns memory |
| rsp_rdata | output | 24 | Read data, zero when not a read |
| acq_active | input | 1 | Acquisition currently enabled |
| acq_done | input | 1 | Run-complete flag from the run counter |
| ld_count | output | 1 | Load strobe for the run counter |
| ld_mode | output | 1 | Load strobe for the mode register |
| arm_pulse | output | 1 | Arm accumulation strobe |
| reg_value | output | 16 | Value for the register load strobes |
| mem_en | output | 1 | Memory port access enable |
| mem_we | output | 1 | Memory port write enable |
| mem_addr | output | 8 | Memory port address |
| mem_wdata | output | 16 | Memory port write data (always zero) |
| mem_rdata | input | 16 | Memory port read data, one cycle after access |

## Verification
The pointer is the only long-lived state. If it is wrong, `mem_addr` is wrong on the very next memory command, and readout data comes from the wrong bin two cycles after that strobe. The bench therefore checks the address and data of every access across full blocks, across the wrap and after a mid-block reset. A command refused as busy or as unknown must leave the pointer where it was, and the command that follows shows this at once. Stage-one and stage-two faults show as a missing or misplaced one-cycle strobe or response, which the bench samples at exact cycles.

// File: rtl/hhp_pkg.sv
// Shared codes for the histogram host port.
// Assumes: function code 5 bits, subaddress 4 bits.
package hhp_pkg;
    localparam int FN_W  = 5;
    localparam int SUB_W = 4;

    localparam logic [FN_W-1:0] FN_READ  = 5'd0;
    localparam logic [FN_W-1:0] FN_CTRL  = 5'd9;
    localparam logic [FN_W-1:0] FN_WRITE = 5'd16;

    localparam logic [SUB_W-1:0] SA_MEM  = 4'd0;
    localparam logic [SUB_W-1:0] SA_FLAG = 4'd1;
    localparam logic [SUB_W-1:0] SA_CNT  = 4'd2;
    localparam logic [SUB_W-1:0] SA_MODE = 4'd3;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_RD_WORD,
        OP_RD_FLAG,
        OP_ADDR_ZERO,
        OP_ARM,
        OP_CLR_WORD,
        OP_LD_CNT,
        OP_LD_MODE
    } op_e;
endpackage

// File: rtl/hhp_decode.sv
// Command decoder: maps function/subaddress to an operation.
// Refuses everything except the flag sense while acquisition is active.
// Assumes: cmd_stb is a single-cycle pulse.
module hhp_decode
    import hhp_pkg::*;
(
    input  logic             stb,
    input  logic [FN_W-1:0]  fn,
    input  logic [SUB_W-1:0] sub,
    input  logic             acq_active,
    output op_e              op,
    output logic             busy
);
    op_e  code;
    logic accept;

    // Purpose: translate the code pair, unknown pairs give OP_NONE.
    always_comb begin
        code = OP_NONE;
        case (fn)
            FN_READ: begin
                if (sub == SA_MEM)       code = OP_RD_WORD;
                else if (sub == SA_FLAG) code = OP_RD_FLAG;
            end
            FN_CTRL: begin
                if (sub == SA_MEM)       code = OP_ADDR_ZERO;
                else if (sub == SA_FLAG) code = OP_ARM;
            end
            FN_WRITE: begin
                if (sub == SA_MEM)       code = OP_CLR_WORD;
                else if (sub == SA_CNT)  code = OP_LD_CNT;
                else if (sub == SA_MODE) code = OP_LD_MODE;
            end
            default: code = OP_NONE;
        endcase
    end

    // Purpose: gate the operation by strobe and acquisition ownership.
    always_comb begin
        accept = stb && (code != OP_NONE) && ((code == OP_RD_FLAG) || !acq_active);
        op     = accept ? code : OP_NONE;
        busy   = stb && (code != OP_NONE) && !accept;
    end
endmodule

// File: rtl/hhp_addr_ctr.sv
// Auto-increment memory pointer; wraps modulo 2**ADDR_W.
// Assumes: clear has priority over increment.
module hhp_addr_ctr #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

    // Purpose: hold the next address to be accessed.
    always_ff @(posedge clk) begin
        if (!rst_n)   addr <= '0;
        else if (clr) addr <= '0;
        else if (inc) addr <= addr + 1'b1;
    end

    assert_addr_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && addr == LAST) |=> (addr == '0));

    assert_addr_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (addr == '0));
endmodule

// File: rtl/hhp_resp.sv
// Response stage: one cycle after stage one, forms status and read data.
// Assumes: memory read data is valid one cycle after the access cycle.
module hhp_resp #(
    parameter int DATA_W = 16,
    parameter int BUS_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s1_ack,
    input  logic              s1_busy,
    input  logic              s1_rd_word,
    input  logic              s1_flag,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic              rsp_busy,
    output logic [BUS_W-1:0]  rsp_rdata
);
    logic rd_word_q;
    logic flag_q;

    // Purpose: register the outcome of the command in stage one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_busy  <= 1'b0;
            rd_word_q <= 1'b0;
            flag_q    <= 1'b0;
        end else begin
            rsp_valid <= s1_ack;
            rsp_busy  <= s1_busy;
            rd_word_q <= s1_ack && s1_rd_word;
            flag_q    <= s1_flag;
        end
    end

    // Purpose: select memory word or status flag, zero-extended.
    always_comb begin
        if (!rsp_valid)     rsp_rdata = '0;
        else if (rd_word_q) rsp_rdata = BUS_W'(mem_rdata);
        else                rsp_rdata = BUS_W'(flag_q);
    end

    assert_resp_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && rsp_busy));

    assert_resp_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s1_ack |=> rsp_valid);
endmodule

// File: rtl/hist_host_port.sv
// Host command port for a histogram memory with auto-increment addressing.
// Stage one registers the decoded command onto the memory port and the
// load strobes; the response follows one cycle later.
// Assumes: one strobe per command, memory read latency of one cycle.
module hist_host_port
    import hhp_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int BUS_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_stb,
    input  logic [4:0]        cmd_fn,
    input  logic [3:0]        cmd_sub,
    input  logic [BUS_W-1:0]  cmd_wdata,
    output logic              rsp_valid,
    output logic              rsp_busy,
    output logic [BUS_W-1:0]  rsp_rdata,
    input  logic              acq_active,
    input  logic              acq_done,
    output logic              ld_count,
    output logic              ld_mode,
    output logic              arm_pulse,
    output logic [DATA_W-1:0] reg_value,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    op_e               op;
    logic              busy;
    logic              mem_op;
    logic [ADDR_W-1:0] ptr;
    logic              s1_ack, s1_busy, s1_rd_word, s1_flag;
    logic              unused_hi;

    assign unused_hi = ^cmd_wdata[BUS_W-1:DATA_W];
    assign mem_wdata = '0;
    assign mem_op    = (op == OP_RD_WORD) || (op == OP_CLR_WORD);

    hhp_decode i_decode (
        .stb        (cmd_stb),
        .fn         (cmd_fn),
        .sub        (cmd_sub),
        .acq_active (acq_active),
        .op         (op),
        .busy       (busy)
    );

    hhp_addr_ctr #(.ADDR_W(ADDR_W)) i_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (op == OP_ADDR_ZERO),
        .inc   (mem_op),
        .addr  (ptr)
    );

    // Purpose: stage one, drive memory port and register load strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_en     <= 1'b0;
            mem_we     <= 1'b0;
            mem_addr   <= '0;
            ld_count   <= 1'b0;
            ld_mode    <= 1'b0;
            arm_pulse  <= 1'b0;
            reg_value  <= '0;
            s1_ack     <= 1'b0;
            s1_busy    <= 1'b0;
            s1_rd_word <= 1'b0;
            s1_flag    <= 1'b0;
        end else begin
            mem_en     <= mem_op;
            mem_we     <= (op == OP_CLR_WORD);
            mem_addr   <= ptr;
            ld_count   <= (op == OP_LD_CNT);
            ld_mode    <= (op == OP_LD_MODE);
            arm_pulse  <= (op == OP_ARM);
            if ((op == OP_LD_CNT) || (op == OP_LD_MODE))
                reg_value <= cmd_wdata[DATA_W-1:0];
            s1_ack     <= (op != OP_NONE);
            s1_busy    <= busy;
            s1_rd_word <= (op == OP_RD_WORD);
            s1_flag    <= acq_done;
        end
    end

    hhp_resp #(.DATA_W(DATA_W), .BUS_W(BUS_W)) i_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .s1_ack     (s1_ack),
        .s1_busy    (s1_busy),
        .s1_rd_word (s1_rd_word),
        .s1_flag    (s1_flag),
        .mem_rdata  (mem_rdata),
        .rsp_valid  (rsp_valid),
        .rsp_busy   (rsp_busy),
        .rsp_rdata  (rsp_rdata)
    );

    assert_busy_no_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && acq_active && !(cmd_fn == FN_READ && cmd_sub == SA_FLAG))
        |=> (!mem_en && !ld_count && !ld_mode && !arm_pulse && $stable(ptr)));

    assert_single_action_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_en, ld_count, ld_mode, arm_pulse}));

    assert_write_is_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_en);
endmodule

// File: tb/test_hist_host_port.sv
`timescale 1ns/100ps
module test_hist_host_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_stb = 1'b0;
    logic [4:0]  cmd_fn = '0;
    logic [3:0]  cmd_sub = '0;
    logic [23:0] cmd_wdata = '0;
    logic        rsp_valid, rsp_busy;
    logic [23:0] rsp_rdata;
    logic        acq_active = 1'b0;
    logic        acq_done = 1'b0;
    logic        ld_count, ld_mode, arm_pulse;
    logic [15:0] reg_value;
    logic        mem_en, mem_we;
    logic [7:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] ram_q;
    logic [15:0] ram [256];
    logic        pl_en = 1'b0;
    logic [7:0]  pl_addr = '0;
    logic [15:0] pl_data = '0;

    int n_checks = 0;
    int n_fail = 0;
    logic        b_en, b_we, b_ldc, b_ldm, b_arm;
    logic [7:0]  b_addr;
    logic [15:0] b_val, b_wd;
    logic        r_valid, r_busy;
    logic [23:0] r_data;

    always #2.5 clk = ~clk;

    hist_host_port i_hist_host_port (
        .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_fn(cmd_fn),
        .cmd_sub(cmd_sub), .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid),
        .rsp_busy(rsp_busy), .rsp_rdata(rsp_rdata), .acq_active(acq_active),
        .acq_done(acq_done), .ld_count(ld_count), .ld_mode(ld_mode),
        .arm_pulse(arm_pulse), .reg_value(reg_value), .mem_en(mem_en),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(ram_q)
    );

    // Memory model of the host port, with a preload path for the bench.
    always @(posedge clk) begin
        if (pl_en) ram[pl_addr] <= pl_data;
        else if (mem_en) begin
            if (mem_we) ram[mem_addr] <= mem_wdata;
            else        ram_q <= ram[mem_addr];
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input int i, input logic [15:0] k);
        return 16'((i * 16'h0101) ^ k);
    endfunction

    task automatic preload(input logic [15:0] k);
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            pl_en = 1'b1; pl_addr = 8'(i); pl_data = pat(i, k);
        end
        @(negedge clk);
        pl_en = 1'b0;
    endtask

    // One command: strobe one cycle, sample stage one, then the response.
    task automatic issue(input logic [4:0] fn, input logic [3:0] sub, input logic [23:0] wd);
        @(negedge clk);
        cmd_stb = 1'b1; cmd_fn = fn; cmd_sub = sub; cmd_wdata = wd;
        @(negedge clk);
        b_en = mem_en; b_we = mem_we; b_addr = mem_addr; b_wd = mem_wdata;
        b_ldc = ld_count; b_ldm = ld_mode; b_arm = arm_pulse; b_val = reg_value;
        cmd_stb = 1'b0;
        @(negedge clk);
        r_valid = rsp_valid; r_busy = rsp_busy; r_data = rsp_rdata;
    endtask

    task automatic t_reset();
        check(!rsp_valid && !rsp_busy && !mem_en && !ld_count && !ld_mode && !arm_pulse,
              "R1", "outputs idle after reset",
              {rsp_valid, rsp_busy, mem_en, ld_count, ld_mode, arm_pulse}, 0);
        issue(5'd0, 4'd0, 24'h0);
        check(b_en && b_addr == 8'd0, "R1", "first access address", b_addr, 0);
    endtask

    task automatic t_clear_block();
        int bad = 0;
        preload(16'h1357);
        issue(5'd9, 4'd0, 24'h0);
        check(r_valid && !r_busy, "R4", "pointer reset answered", r_valid, 1);
        for (int i = 0; i < 256; i++) begin
            issue(5'd16, 4'd0, 24'hFFFFFF);
            check(b_en && b_we && b_addr == 8'(i) && b_wd == 16'h0, "R2",
                  "clear access address", b_addr, i);
            check(r_valid, "R2", "clear answered", r_valid, 1);
        end
        for (int i = 0; i < 256; i++) if (ram[i] != 16'h0) bad++;
        check(bad == 0, "R2", "words left nonzero", bad, 0);
        issue(5'd0, 4'd0, 24'h0);
        check(b_addr == 8'd0 && !b_we, "R5", "pointer wrapped after clear", b_addr, 0);
        check(r_data == 24'h0, "R2", "cleared word readback", r_data, 0);
    endtask

    task automatic t_readout();
        preload(16'h5A3C);
        issue(5'd9, 4'd0, 24'h0);
        for (int i = 0; i < 256; i++) begin
            issue(5'd0, 4'd0, 24'h0);
            check(b_en && !b_we && b_addr == 8'(i), "R3", "read address", b_addr, i);
            check(r_valid && r_data == {8'h00, pat(i, 16'h5A3C)}, "R3", "read data",
                  r_data, {8'h00, pat(i, 16'h5A3C)});
        end
        issue(5'd0, 4'd0, 24'h0);
        check(b_addr == 8'd0, "R5", "pointer wrapped after readout", b_addr, 0);
        check(r_data == {8'h00, pat(0, 16'h5A3C)}, "R5", "data after wrap",
              r_data, {8'h00, pat(0, 16'h5A3C)});
        issue(5'd0, 4'd0, 24'h0);
        issue(5'd0, 4'd0, 24'h0);
        issue(5'd9, 4'd0, 24'h0);
        issue(5'd0, 4'd0, 24'h0);
        check(b_addr == 8'd0, "R4", "mid-block pointer reset", b_addr, 0);
    endtask

    task automatic t_loads();
        issue(5'd16, 4'd2, 24'hAB1234);
        check(b_ldc && !b_ldm && !b_arm && !b_en && b_val == 16'h1234, "R6",
              "count load strobe and value", {b_ldc, b_ldm, b_arm, b_val}, {3'b100, 16'h1234});
        check(r_valid && !ld_count, "R6", "count strobe one cycle", ld_count, 0);
        issue(5'd16, 4'd3, 24'h000001);
        check(b_ldm && !b_ldc && !b_arm && b_val[0], "R7", "mode load strobe",
              {b_ldm, b_val[0]}, 2'b11);
        check(!ld_mode, "R7", "mode strobe one cycle", ld_mode, 0);
        issue(5'd9, 4'd1, 24'h0);
        check(b_arm && !b_ldc && !b_ldm && !b_en, "R8", "arm pulse",
              {b_arm, b_ldc, b_ldm, b_en}, 4'b1000);
        check(r_valid && !arm_pulse, "R8", "arm one cycle", arm_pulse, 0);
    endtask

    task automatic t_flag();
        acq_done = 1'b1;
        issue(5'd0, 4'd1, 24'h0);
        check(r_valid && r_data == 24'h1, "R9", "flag set read", r_data, 1);
        acq_done = 1'b0;
        issue(5'd0, 4'd1, 24'h0);
        check(r_valid && r_data == 24'h0, "R9", "flag clear read", r_data, 0);
    endtask

    task automatic t_busy();
        issue(5'd9, 4'd0, 24'h0);
        issue(5'd0, 4'd0, 24'h0);
        issue(5'd0, 4'd0, 24'h0);
        acq_active = 1'b1;
        issue(5'd16, 4'd0, 24'h0);
        check(!b_en && r_busy && !r_valid, "R10", "clear refused",
              {b_en, r_busy, r_valid}, 3'b010);
        issue(5'd0, 4'd0, 24'h0);
        check(!b_en && r_busy && !r_valid, "R10", "read refused",
              {b_en, r_busy, r_valid}, 3'b010);
        issue(5'd9, 4'd0, 24'h0);
        check(r_busy && !r_valid, "R10", "pointer reset refused", r_busy, 1);
        issue(5'd16, 4'd2, 24'h0055);
        check(!b_ldc && r_busy, "R10", "count load refused", b_ldc, 0);
        issue(5'd9, 4'd1, 24'h0);
        check(!b_arm && r_busy, "R10", "arm refused", b_arm, 0);
        acq_done = 1'b1;
        issue(5'd0, 4'd1, 24'h0);
        check(r_valid && !r_busy && r_data == 24'h1, "R9", "flag served while active",
              r_data, 1);
        acq_done = 1'b0;
        acq_active = 1'b0;
        issue(5'd0, 4'd0, 24'h0);
        check(b_en && b_addr == 8'd2, "R10", "pointer kept after refusals", b_addr, 2);
    endtask

    task automatic t_unknown();
        issue(5'd3, 4'd0, 24'h0);
        check(!b_en && !b_ldc && !b_ldm && !b_arm && !r_valid && !r_busy, "R11",
              "unknown function silent", {b_en, r_valid, r_busy}, 0);
        issue(5'd16, 4'd1, 24'h0);
        check(!b_en && !r_valid && !r_busy, "R11", "unknown subaddress silent",
              {b_en, r_valid, r_busy}, 0);
        issue(5'd9, 4'd7, 24'h0);
        check(!b_arm && !r_valid && !r_busy, "R11", "unknown control silent",
              {b_arm, r_valid, r_busy}, 0);
        issue(5'd0, 4'd0, 24'h0);
        check(b_addr == 8'd3, "R11", "pointer kept after unknown", b_addr, 3);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clear_block();
        t_readout();
        t_loads();
        t_flag();
        t_busy();
        t_unknown();
        finish_run();
    end
endmodule